// File: doc/BRIEF.md
# Interleaving Address Range Router

This block sits in a memory interconnect port, at a host bridge or the upstream side of a switch, and chooses the downstream port for each memory request. It holds a bank of independently programmed range decoders. Each decoder covers a contiguous span of host physical address space. A decoder can send its whole span to one port, or it can interleave the span across two or four ports. The port is chosen from address bits at a programmable granularity.

When an upper level of the hierarchy has already interleaved the traffic, a decoder can be told how many selection bits that level used. Its own way-select bits are then taken from above them.

Software programs each decoder through a narrow write port, one field at a time, and then sets a commit bit. Only committed decoders take part in matching. The geometry of a committed decoder is frozen until it is uncommitted again. Every request that arrives with a valid strobe gets a registered answer on the next cycle. The answer is either a hit carrying a port number or a miss.

Top module: `addr_route_bank`

## Requirements
- R1: After reset, rsp_valid, rsp_hit and rsp_miss are 0, and every decoder is uncommitted, so any request misses.
- R2: A committed decoder matches an address when base <= addr and addr - base < size. The address base+size-1 matches, and base-1 and base+size do not.
- R3: A decoder whose commit bit is clear never matches, whatever its base, size and targets are.
- R4: With a way code of 0 (one way), every hit in the decoder returns target slot 0. Target slot k sits at cfg_wdata bits [k*3 +: 3] of a target-field write.
- R5: The mode field is 8 bits. Bits [1:0] give log2 of the way count: 0 means 1 way, 1 means 2 ways, 2 means 4 ways, and 3 is treated as 2. The way index is (addr >> shift) mod ways, and the port is the target slot at that index.
- R6: Mode bits [5:2] hold a granularity code g. The granularity is 2^(8+g) bytes, so code 4 selects 4 KiB and code 5 selects 8 KiB.
- R7: Mode bits [7:6] hold u, the number of selection bits an upstream level has already used. The shift is 8+g+u, so the way bits of this level lie above the upstream bits.
- R8: When several committed decoders match, the one with the lowest index decides the port.
- R9: A valid request that matches no committed decoder returns rsp_miss=1, rsp_hit=0 and rsp_port=0.
- R10: While a decoder is committed, writes to its base (field 0), size (field 1), mode (field 2) and targets (field 3) are ignored. Writes to its commit field (field 4, bit 0) always take effect.
- R11: A request presented with req_valid in one cycle is answered with rsp_valid exactly one cycle later. rsp_valid is 0 in the cycle after no request, and rsp_hit and rsp_miss are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dec | input | 3 | Index of the decoder being written |
| cfg_field | input | 3 | Field select: 0 base, 1 size, 2 mode, 3 targets, 4 commit |
| cfg_wdata | input | 48 | Write data for the selected field |
| req_valid | input | 1 | Request address is valid |
| req_addr | input | 48 | Host physical address of the request |
| rsp_valid | output | 1 | Registered result is valid |
| rsp_hit | output | 1 | A committed decoder matched |
| rsp_miss | output | 1 | No committed decoder matched |
| rsp_port | output | 3 | Selected downstream port, 0 on a miss |

## Verification
The hardest case to reach is a decoder whose way bits sit above an upstream level's selection bits. At that point the granularity code, the upstream count and the way count all add into one shift. The stimulus programs an 8 KiB, two-way decoder with one upstream bit. It then steps addresses across bits 13 and 14 separately, so a shift that is off by one lands on the wrong port. Overlapping decoders are also committed and uncommitted in turn, and writes are aimed at a locked decoder. The scoreboard model then shows whether priority and locking held.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    // Configuration field selector
    typedef enum logic [2:0] {
        FLD_BASE   = 3'd0,
        FLD_SIZE   = 3'd1,
        FLD_MODE   = 3'd2,
        FLD_TGT    = 3'd3,
        FLD_COMMIT = 3'd4
    } cfg_fld_e;

    // Smallest granularity is 2^GRAN_LOG_MIN bytes
    localparam int unsigned GRAN_LOG_MIN = 8;

    // Interleave geometry of one decoder (8 bits, MSB first)
    typedef struct packed {
        logic [1:0] up_bits;    // selection bits consumed upstream
        logic [3:0] gran_code;  // granularity = 2^(GRAN_LOG_MIN + code)
        logic [1:0] ways_log;   // log2 of way count
    } mode_t;

    // Bit position of the lowest way-select bit of this level
    function automatic logic [5:0] way_shift(input mode_t m);
        return 6'(GRAN_LOG_MIN) + 6'(m.gran_code) + 6'(m.up_bits);
    endfunction

endpackage

// File: rtl/ilv_dec_slot.sv
module ilv_dec_slot
    import ilv_pkg::*;
#(
    parameter int ADDR_W   = 48,
    parameter int PORT_W   = 3,
    parameter int NTGT_LOG = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [2:0]                    wr_fld,
    input  logic [ADDR_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             req_addr,
    output logic                          hit,
    output logic [PORT_W-1:0]             port
);
    localparam int NTGT   = 1 << NTGT_LOG;
    localparam int TGT_BW = NTGT * PORT_W;
    localparam int MODE_W = $bits(mode_t);

    logic [ADDR_W-1:0] base_q, size_q;
    mode_t             mode_q;
    logic [TGT_BW-1:0] tgts_q;
    logic              commit_q;
    cfg_fld_e          fld;

    assign fld = cfg_fld_e'(wr_fld);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            size_q   <= '0;
            mode_q   <= '0;
            tgts_q   <= '0;
            commit_q <= 1'b0;
        end else if (wr_en) begin
            case (fld)
                FLD_BASE:   if (!commit_q) base_q <= wr_data;
                FLD_SIZE:   if (!commit_q) size_q <= wr_data;
                FLD_MODE:   if (!commit_q) mode_q <= mode_t'(wr_data[MODE_W-1:0]);
                FLD_TGT:    if (!commit_q) tgts_q <= wr_data[TGT_BW-1:0];
                FLD_COMMIT: commit_q <= wr_data[0];
                default:    ;
            endcase
        end
    end

    // Range match
    logic [ADDR_W-1:0] offset;
    logic              in_range;
    assign offset   = req_addr - base_q;
    assign in_range = commit_q && (req_addr >= base_q) && (offset < size_q);

    // Way selection
    logic [NTGT_LOG-1:0] idx_raw, idx_mask, idx;
    logic [1:0]          wlog;
    always_comb begin
        wlog     = (32'(mode_q.ways_log) > NTGT_LOG) ? 2'(NTGT_LOG) : mode_q.ways_log;
        idx_raw  = NTGT_LOG'(req_addr >> way_shift(mode_q));
        idx_mask = NTGT_LOG'((1 << wlog) - 1);
        idx      = idx_raw & idx_mask;
    end

    assign hit  = in_range;
    assign port = tgts_q[idx*PORT_W +: PORT_W];

    // R10: committed geometry is frozen against non-commit writes
    a_r10_locked_geometry: assert property (@(posedge clk) disable iff (rst)
        (wr_en && commit_q && fld != FLD_COMMIT)
        |=> ($stable(base_q) && $stable(size_q) && $stable(mode_q) && $stable(tgts_q)))
        else $error("a_r10_locked_geometry");

endmodule

// File: rtl/ilv_first_hit.sv
module ilv_first_hit #(
    parameter int N      = 6,
    parameter int PORT_W = 3
) (
    input  logic [N-1:0]        hits,
    input  logic [N*PORT_W-1:0] ports,
    output logic                any_hit,
    output logic [PORT_W-1:0]   sel_port
);
    // Scan downward so the lowest matching index is assigned last and wins
    always_comb begin
        any_hit  = 1'b0;
        sel_port = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any_hit  = 1'b1;
                sel_port = ports[i*PORT_W +: PORT_W];
            end
        end
    end
endmodule

// File: rtl/addr_route_bank.sv
module addr_route_bank
    import ilv_pkg::*;
#(
    parameter int ADDR_W   = 48,
    parameter int NUM_DEC  = 6,
    parameter int PORT_W   = 3,
    parameter int NTGT_LOG = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [$clog2(NUM_DEC)-1:0]  cfg_dec,
    input  logic [2:0]                  cfg_field,
    input  logic [ADDR_W-1:0]           cfg_wdata,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    output logic                        rsp_valid,
    output logic                        rsp_hit,
    output logic                        rsp_miss,
    output logic [PORT_W-1:0]           rsp_port
);
    localparam int DEC_W = $clog2(NUM_DEC);

    logic [NUM_DEC-1:0]        hit_v;
    logic [NUM_DEC*PORT_W-1:0] port_v;
    logic                      any_hit;
    logic [PORT_W-1:0]         pick;

    for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
        ilv_dec_slot #(
            .ADDR_W  (ADDR_W),
            .PORT_W  (PORT_W),
            .NTGT_LOG(NTGT_LOG)
        ) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (cfg_we && (cfg_dec == DEC_W'(i))),
            .wr_fld  (cfg_field),
            .wr_data (cfg_wdata),
            .req_addr(req_addr),
            .hit     (hit_v[i]),
            .port    (port_v[i*PORT_W +: PORT_W])
        );
    end

    ilv_first_hit #(.N(NUM_DEC), .PORT_W(PORT_W)) u_pick (
        .hits    (hit_v),
        .ports   (port_v),
        .any_hit (any_hit),
        .sel_port(pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_port  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && any_hit;
            rsp_miss  <= req_valid && !any_hit;
            rsp_port  <= (req_valid && any_hit) ? pick : '0;
        end
    end

    // R11: one-cycle answer, silence after idle, exclusive flags
    a_r11_answer_next: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid) else $error("a_r11_answer_next");
    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss)) else $error("a_r11_quiet_idle");
    a_r11_one_flag: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_miss)) else $error("a_r11_one_flag");
    // R9: a miss carries port 0
    a_r9_miss_port_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_port == '0)) else $error("a_r9_miss_port_zero");

endmodule

// File: tb/sim_addr_route_bank.sv
module sim_addr_route_bank;
    localparam int AW = 48;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [2:0]    cfg_dec;
    logic [2:0]    cfg_field;
    logic [AW-1:0] cfg_wdata;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          rsp_valid, rsp_hit, rsp_miss;
    logic [2:0]    rsp_port;

    always #5 clk = ~clk;

    addr_route_bank u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_dec(cfg_dec),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_port(rsp_port)
    );

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic        hit;
        logic [2:0]  port;
        string       tag;
    } exp_t;
    exp_t sq[$];

    // Bench mirror of the programmed state, following the requirements
    logic [AW-1:0] m_base [6];
    logic [AW-1:0] m_size [6];
    logic [7:0]    m_mode [6];
    logic [11:0]   m_tgt  [6];
    logic          m_com  [6];

    function automatic void model(input logic [AW-1:0] a, output logic h, output logic [2:0] p);
        h = 1'b0; p = 3'd0;
        for (int d = 5; d >= 0; d--) begin
            if (m_com[d] && a >= m_base[d] && (a - m_base[d]) < m_size[d]) begin
                int wl, sh, ix;
                wl = (m_mode[d][1:0] > 2) ? 2 : int'(m_mode[d][1:0]);
                sh = 8 + int'(m_mode[d][5:2]) + int'(m_mode[d][7:6]);
                ix = int'((a >> sh) & AW'((1 << wl) - 1));
                h = 1'b1;
                p = m_tgt[d][ix*3 +: 3];
            end
        end
    endfunction

    function automatic logic [AW-1:0] tg(input int t0, input int t1, input int t2, input int t3);
        return AW'({3'(t3), 3'(t2), 3'(t1), 3'(t0)});
    endfunction

    function automatic logic [AW-1:0] md(input int wl, input int gc, input int up);
        return AW'({2'(up), 4'(gc), 2'(wl)});
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic cfg(input int d, input int f, input logic [AW-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dec = 3'(d); cfg_field = 3'(f); cfg_wdata = v;
        if (f == 4) m_com[d] = v[0];
        else if (!m_com[d]) begin
            case (f)
                0: m_base[d] = v;
                1: m_size[d] = v;
                2: m_mode[d] = v[7:0];
                3: m_tgt[d]  = v[11:0];
                default: ;
            endcase
        end
        @(posedge clk); #1 cfg_we = 1'b0;
    endtask

    // Driver: present one request, push the expected answer
    task automatic req(input logic [AW-1:0] a, input string tag, input bit hold);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        model(a, e.hit, e.port);
        e.tag = tag;
        sq.push_back(e);
        if (!hold) begin @(posedge clk); #1 req_valid = 1'b0; end
    endtask

    // Monitor: compare each response with the head of the scoreboard
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sq.size() == 0) begin
                check(1'b0, "R11", "unexpected rsp_valid", 1, 0);
            end else begin
                exp_t e;
                e = sq.pop_front();
                check(rsp_hit == e.hit && rsp_miss == !e.hit, e.tag, "hit flag",
                      int'(rsp_hit), int'(e.hit));
                check(rsp_port == e.port, e.tag, "port", int'(rsp_port), int'(e.port));
            end
        end
    end

    initial begin
        #1_000_000;
        check(1'b0, "R11", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int d = 0; d < 6; d++) begin
            m_base[d] = '0; m_size[d] = '0; m_mode[d] = '0; m_tgt[d] = '0; m_com[d] = 1'b0;
        end
        rst = 1'b1; cfg_we = 1'b0; cfg_dec = '0; cfg_field = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!rsp_valid && !rsp_hit && !rsp_miss, "R1", "outputs after reset",
              int'({rsp_valid, rsp_hit, rsp_miss}), 0);
        req(48'h1000_0000, "R1", 0);

        // Decoder 0: one way to port 5; before commit it must miss (R3)
        cfg(0, 0, 48'h1000_0000);
        cfg(0, 1, 48'h0100_0000);
        cfg(0, 2, md(0, 4, 0));
        cfg(0, 3, tg(5, 1, 1, 1));
        req(48'h1000_0040, "R3", 0);
        cfg(0, 4, 48'h1);
        // R2, R4, R9: range edges
        req(48'h1000_0000, "R4", 0);
        req(48'h0FFF_FFFF, "R9", 0);
        req(48'h10FF_FFFF, "R2", 0);
        req(48'h1100_0000, "R2", 0);
        req(48'h1080_3000, "R4", 0);

        // Decoder 1: four ways, 4 KiB, targets 1..4 (R5, R6)
        cfg(1, 0, 48'h2000_0000);
        cfg(1, 1, 48'h1000_0000);
        cfg(1, 2, md(2, 4, 0));
        cfg(1, 3, tg(1, 2, 3, 4));
        cfg(1, 4, 48'h1);
        // back-to-back burst (R11)
        for (int k = 0; k < 6; k++) req(48'h2000_0000 + AW'(k) * 48'h1000, "R5", 1);
        req(48'h2000_0FFF, "R6", 0);

        // Decoder 2: two ways, 8 KiB, one upstream bit -> shift 14 (R7)
        cfg(2, 0, 48'h3000_0000);
        cfg(2, 1, 48'h1000_0000);
        cfg(2, 2, md(1, 5, 1));
        cfg(2, 3, tg(6, 7, 0, 0));
        cfg(2, 4, 48'h1);
        req(48'h3000_2000, "R7", 0);
        req(48'h3000_4000, "R7", 0);
        req(48'h3000_6000, "R7", 0);
        req(48'h3000_8000, "R7", 0);
        // way code 3 treated as 2 (R5) on decoder 4
        cfg(4, 0, 48'h4000_0000);
        cfg(4, 1, 48'h0010_0000);
        cfg(4, 2, md(3, 0, 0));
        cfg(4, 3, tg(0, 1, 2, 3));
        cfg(4, 4, 48'h1);
        req(48'h4000_0300, "R5", 0);
        req(48'h4000_0700, "R5", 0);

        // Decoder 3 overlaps decoder 0 (R8)
        cfg(3, 0, 48'h1000_0000);
        cfg(3, 1, 48'h2000_0000);
        cfg(3, 3, tg(2, 0, 0, 0));
        cfg(3, 4, 48'h1);
        req(48'h1000_1000, "R8", 0);
        req(48'h1800_0000, "R8", 0);
        req(48'h2000_5000, "R8", 0);

        // Locked decoder 1 ignores geometry writes (R10)
        cfg(1, 0, 48'h5000_0000);
        cfg(1, 3, tg(0, 0, 0, 0));
        cfg(1, 2, md(0, 4, 0));
        req(48'h2000_1000, "R10", 0);
        req(48'h2000_3000, "R10", 0);
        req(48'h5000_0000, "R10", 0);
        // Uncommit, reprogram, recommit takes effect (R10)
        cfg(1, 4, 48'h0);
        cfg(1, 3, tg(7, 6, 5, 4));
        cfg(1, 4, 48'h1);
        req(48'h2000_1000, "R10", 0);
        // Uncommit decoder 0: overlap falls through to decoder 3 (R8, R3)
        cfg(0, 4, 48'h0);
        req(48'h1000_1000, "R3", 0);

        repeat (4) @(negedge clk);
        // R11: every request answered
        check(sq.size() == 0, "R11", "pending answers", sq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule